// File: doc/BRIEF.md
# Resizable Miss Tracking Register File

This block tracks outstanding cache misses for a non-blocking private cache. Each entry holds a block address, an ordered list of waiting request targets, and a lifecycle state. An incoming miss is compared against every waiting entry at once. A matching miss with room left is appended to that entry as one more target. A miss with no match takes a free entry and issues a single memory request. When a miss cannot be taken, the block raises a blocked indication in the same cycle.

A run-time input sets how many entries may be occupied at once, and which entry indices may be handed out. A controller can move this limit up or down while misses are in flight, which throttles the number of outstanding memory requests the cache places on the shared memory system. When a fill returns for an entry, the block hands that entry's targets back one per accepted beat, in arrival order. It releases the entry after the last beat.

Top module: `miss_track_file`

## Requirements
- R1: After reset, every entry is free. `blocked`, `mem_req_valid` and `tgt_valid` are low, and `fill_ready` is high.
- R2: A miss with no waiting-entry match is accepted when occupancy is below `cfg_limit`. It takes the lowest-numbered free entry whose index is below `cfg_limit`. In the same cycle `mem_req_valid` pulses with `mem_req_addr` equal to the miss address and `mem_req_id` equal to that index.
- R3: A miss whose address equals that of a waiting entry holding fewer than NUM_TGT targets is appended to that entry. No memory request is issued and `blocked` stays low.
- R4: A miss that matches a waiting entry already holding NUM_TGT targets raises `blocked` and is not recorded.
- R5: A non-matching miss raises `blocked` and issues no request while occupancy is at or above `cfg_limit`.
- R6: Lowering `cfg_limit` below the current occupancy leaves existing entries draining normally. New allocations resume only once occupancy falls below the new limit.
- R7: A fill is accepted when `fill_valid` and `fill_ready` are high and `fill_id` names a waiting entry. The entry's targets then appear on `tgt_data` in arrival order, one per `tgt_valid`/`tgt_ready` handshake. `tgt_id` carries the entry index, and `tgt_last` is high on the final target.
- R8: While targets are being returned, `fill_ready` is low. A stalled beat holds `tgt_data` and `tgt_id` steady. The entry becomes free for allocation after the last handshake.
- R9: A miss to the address of an entry whose targets are being returned is not merged into it. It is treated as a non-matching miss.
- R10: `blocked` is high only in a cycle where `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_limit | input | CNT_W | Number of entries allowed to be occupied (0..NUM_ENT) |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Block address of the miss |
| req_tgt | input | TGT_W | Target information of the miss |
| blocked | output | 1 | Miss cannot be taken this cycle |
| mem_req_valid | output | 1 | One-cycle memory request for a new entry |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| mem_req_id | output | IDX_W | Entry index tagging the request |
| fill_valid | input | 1 | Fill completion for an entry |
| fill_id | input | IDX_W | Entry index of the completed fill |
| fill_ready | output | 1 | Completion can be accepted |
| tgt_valid | output | 1 | Returned target present |
| tgt_ready | input | 1 | Consumer takes the returned target |
| tgt_data | output | TGT_W | Returned target information |
| tgt_id | output | IDX_W | Entry the target belongs to |
| tgt_last | output | 1 | Final target of the entry |

## Verification
The bench builds the block with four entries, two target slots per entry, 16-bit addresses and 8-bit targets. With only two slots, one merge already fills an entry, so the full-entry stall is a single request away. With four entries, the whole file can be occupied and the limit cut to two below occupancy within a few dozen cycles. The lowest-index choice and reuse of a freed entry can be observed after a single fill. A stalled return with a same-address miss arriving during the drain is also within reach.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_WAIT  = 2'd1,
    ENT_DRAIN = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mtf_match.sv
module mtf_match #(
  parameter int NUM_ENT = 8,
  parameter int ADDR_W  = 26,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [ADDR_W-1:0]              key,
  input  logic [NUM_ENT-1:0][ADDR_W-1:0] ent_addr,
  input  logic [NUM_ENT-1:0]             live,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [NUM_ENT-1:0] hit_vec;

  // one comparator per entry
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign hit_vec[g] = live[g] && (ent_addr[g] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/mtf_pick.sv
module mtf_pick #(
  parameter int NUM_ENT = 8,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
  input  logic [NUM_ENT-1:0] free_vec,
  input  logic [CNT_W-1:0]   limit,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_ENT-1:0] cand;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_en
    assign cand[g] = free_vec[g] && (CNT_W'(g) < limit);
  end

  assign found = |cand;

  always_comb begin
    idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/miss_track_file.sv
module miss_track_file #(
  parameter int NUM_ENT = 8,
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 26,
  parameter int TGT_W   = 8,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CNT_W  = $clog2(NUM_ENT + 1),
  localparam int TC_W   = $clog2(NUM_TGT + 1),
  localparam int TP_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TGT_W-1:0]  req_tgt,
  output logic              blocked,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [IDX_W-1:0]  mem_req_id,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_id,
  output logic              fill_ready,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic [TGT_W-1:0]  tgt_data,
  output logic [IDX_W-1:0]  tgt_id,
  output logic              tgt_last
);
  import mtf_pkg::*;

  // entry state
  ent_state_e [NUM_ENT-1:0]              st_q, st_d;
  logic [NUM_ENT-1:0][TC_W-1:0]          tcnt_q, tcnt_d;
  logic [NUM_ENT-1:0][ADDR_W-1:0]        addr_q, addr_d;
  logic [NUM_ENT-1:0][NUM_TGT-1:0][TGT_W-1:0] tgt_q, tgt_d;
  logic [CNT_W-1:0]                      occ_q, occ_d;

  // drain state
  logic             drn_act_q, drn_act_d;
  logic [IDX_W-1:0] drn_idx_q, drn_idx_d;
  logic [TC_W-1:0]  drn_ptr_q, drn_ptr_d;

  logic [NUM_ENT-1:0] wait_vec, free_vec;
  logic               hit, pick_found;
  logic [IDX_W-1:0]   hit_idx, pick_idx;
  logic               merge_ok, alloc_ok, fill_go, pop, done;
  logic               ent_we, drn_we, occ_we;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_vec
    assign wait_vec[g] = (st_q[g] == ENT_WAIT);
    assign free_vec[g] = (st_q[g] == ENT_FREE);
  end

  mtf_match #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_match (
    .key     (req_addr),
    .ent_addr(addr_q),
    .live    (wait_vec),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  mtf_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .free_vec(free_vec),
    .limit   (cfg_limit),
    .found   (pick_found),
    .idx     (pick_idx)
  );

  // request side
  assign merge_ok = req_valid && hit && (tcnt_q[hit_idx] < TC_W'(NUM_TGT));
  assign alloc_ok = req_valid && !hit && pick_found && (occ_q < cfg_limit);
  assign blocked  = req_valid && !merge_ok && !alloc_ok;

  assign mem_req_valid = alloc_ok;
  assign mem_req_addr  = req_addr;
  assign mem_req_id    = pick_idx;

  // completion side
  assign fill_ready = !drn_act_q;
  assign fill_go    = fill_valid && fill_ready && (st_q[fill_id] == ENT_WAIT);

  assign tgt_valid = drn_act_q;
  assign tgt_id    = drn_idx_q;
  assign tgt_data  = tgt_q[drn_idx_q][drn_ptr_q[TP_W-1:0]];
  assign tgt_last  = ((drn_ptr_q + TC_W'(1)) == tcnt_q[drn_idx_q]);
  assign pop       = tgt_valid && tgt_ready;
  assign done      = pop && tgt_last;

  assign ent_we = alloc_ok || merge_ok || fill_go || done;
  assign drn_we = fill_go || pop;
  assign occ_we = alloc_ok || done;

  // next state: entries
  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    addr_d = addr_q;
    tgt_d  = tgt_q;
    if (alloc_ok) begin
      st_d[pick_idx]      = ENT_WAIT;
      tcnt_d[pick_idx]    = TC_W'(1);
      addr_d[pick_idx]    = req_addr;
      tgt_d[pick_idx][0]  = req_tgt;
    end
    if (merge_ok) begin
      tcnt_d[hit_idx] = tcnt_q[hit_idx] + TC_W'(1);
      tgt_d[hit_idx][tcnt_q[hit_idx][TP_W-1:0]] = req_tgt;
    end
    if (fill_go) st_d[fill_id]   = ENT_DRAIN;
    if (done)    st_d[drn_idx_q] = ENT_FREE;
  end

  // next state: occupancy
  always_comb begin
    occ_d = occ_q;
    if (alloc_ok && !done)      occ_d = occ_q + CNT_W'(1);
    else if (!alloc_ok && done) occ_d = occ_q - CNT_W'(1);
  end

  // next state: drain sequencer
  always_comb begin
    drn_act_d = drn_act_q;
    drn_idx_d = drn_idx_q;
    drn_ptr_d = drn_ptr_q;
    if (fill_go) begin
      drn_act_d = 1'b1;
      drn_idx_d = fill_id;
      drn_ptr_d = '0;
    end else if (pop) begin
      if (tgt_last) drn_act_d = 1'b0;
      else          drn_ptr_d = drn_ptr_q + TC_W'(1);
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= {NUM_ENT{ENT_FREE}};
      tcnt_q <= '0;
    end else if (ent_we) begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_we) occ_q <= occ_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drn_act_q <= 1'b0;
      drn_idx_q <= '0;
      drn_ptr_q <= '0;
    end else if (drn_we) begin
      drn_act_q <= drn_act_d;
      drn_idx_q <= drn_idx_d;
      drn_ptr_q <= drn_ptr_d;
    end
  end

  // payload registers, no reset
  always_ff @(posedge clk) begin
    if (alloc_ok || merge_ok) begin
      addr_q <= addr_d;
      tgt_q  <= tgt_d;
    end
  end
endmodule

// File: rtl/mtf_checker.sv
module mtf_checker #(
  parameter int NUM_ENT = 8,
  parameter int TGT_W   = 8,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cfg_limit,
  input logic             req_valid,
  input logic             blocked,
  input logic             mem_req_valid,
  input logic [IDX_W-1:0] mem_req_id,
  input logic [CNT_W-1:0] occ_q,
  input logic             fill_ready,
  input logic             tgt_valid,
  input logic             tgt_ready,
  input logic [TGT_W-1:0] tgt_data,
  input logic [IDX_W-1:0] tgt_id
);
  AST_REQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (req_valid && !blocked)); // R2

  AST_ID_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (CNT_W'(mem_req_id) < cfg_limit)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (occ_q < cfg_limit)); // R5

  AST_BLOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> req_valid); // R10

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_data) && $stable(tgt_id))); // R8

  AST_NO_FILL_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> !fill_ready); // R8

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(NUM_ENT)); // R6
endmodule

bind miss_track_file mtf_checker #(.NUM_ENT(NUM_ENT), .TGT_W(TGT_W)) u_mtf_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_limit    (cfg_limit),
  .req_valid    (req_valid),
  .blocked      (blocked),
  .mem_req_valid(mem_req_valid),
  .mem_req_id   (mem_req_id),
  .occ_q        (occ_q),
  .fill_ready   (fill_ready),
  .tgt_valid    (tgt_valid),
  .tgt_ready    (tgt_ready),
  .tgt_data     (tgt_data),
  .tgt_id       (tgt_id)
);

// File: tb/test_miss_track_file.sv
`timescale 1ns/1ps
module test_miss_track_file;
  localparam int NE = 4;
  localparam int NT = 2;
  localparam int AW = 16;
  localparam int TW = 8;
  localparam int IW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_limit;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [TW-1:0] req_tgt;
  logic          blocked;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [IW-1:0] mem_req_id;
  logic          fill_valid;
  logic [IW-1:0] fill_id;
  logic          fill_ready;
  logic          tgt_valid;
  logic          tgt_ready;
  logic [TW-1:0] tgt_data;
  logic [IW-1:0] tgt_id;
  logic          tgt_last;

  int n_chk = 0;
  int n_bad = 0;

  logic [AW+IW-1:0] exp_mem[$];
  logic [TW+IW:0]   exp_tgt[$];

  always #2.5 clk = ~clk;

  miss_track_file #(.NUM_ENT(NE), .NUM_TGT(NT), .ADDR_W(AW), .TGT_W(TW)) i_miss_track_file (
    .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit),
    .req_valid(req_valid), .req_addr(req_addr), .req_tgt(req_tgt), .blocked(blocked),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_id(mem_req_id),
    .fill_valid(fill_valid), .fill_id(fill_id), .fill_ready(fill_ready),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_data(tgt_data),
    .tgt_id(tgt_id), .tgt_last(tgt_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares produced results against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_req_valid) begin
      if (exp_mem.size() == 0) check(1'b0, "R2 unexpected mem request", int'({mem_req_addr, mem_req_id}), 0);
      else begin
        logic [AW+IW-1:0] e;
        e = exp_mem.pop_front();
        check({mem_req_addr, mem_req_id} == e, "R2 mem request addr/id", int'({mem_req_addr, mem_req_id}), int'(e));
      end
    end
    if (rst_n && tgt_valid && tgt_ready) begin
      if (exp_tgt.size() == 0) check(1'b0, "R7 unexpected target", int'({tgt_last, tgt_id, tgt_data}), 0);
      else begin
        logic [TW+IW:0] e;
        e = exp_tgt.pop_front();
        check({tgt_last, tgt_id, tgt_data} == e, "R7 target last/id/data", int'({tgt_last, tgt_id, tgt_data}), int'(e));
      end
    end
  end

  task automatic push_mem(input logic [AW-1:0] a, input logic [IW-1:0] id);
    exp_mem.push_back({a, id});
  endtask

  task automatic push_tgt(input logic [TW-1:0] d, input logic [IW-1:0] id, input logic last);
    exp_tgt.push_back({last, id, d});
  endtask

  task automatic miss(input logic [AW-1:0] a, input logic [TW-1:0] t, input bit exp_blk, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_tgt = t;
    #1;
    check(blocked == exp_blk, tag, int'(blocked), int'(exp_blk));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill_pulse(input logic [IW-1:0] id);
    @(negedge clk);
    fill_valid = 1'b1; fill_id = id;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_tgt.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_limit = 3'd4; req_valid = 1'b0; req_addr = '0; req_tgt = '0;
    fill_valid = 1'b0; fill_id = '0; tgt_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(blocked == 1'b0,       "R1 blocked",       int'(blocked), 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);
    check(tgt_valid == 1'b0,     "R1 tgt_valid",     int'(tgt_valid), 0);
    check(fill_ready == 1'b1,    "R1 fill_ready",    int'(fill_ready), 1);

    // R2 allocation lowest first, R3 merge, R4 full entry
    push_mem(16'h0100, 2'd0); miss(16'h0100, 8'd1, 1'b0, "R2 alloc A");
    push_mem(16'h0200, 2'd1); miss(16'h0200, 8'd2, 1'b0, "R2 alloc B");
    miss(16'h0100, 8'd3, 1'b0, "R3 merge into A");
    miss(16'h0100, 8'd4, 1'b1, "R4 A targets full");
    push_mem(16'h0300, 2'd2); miss(16'h0300, 8'd9,  1'b0, "R2 alloc C");
    push_mem(16'h0400, 2'd3); miss(16'h0400, 8'd10, 1'b0, "R2 alloc D");
    miss(16'h0500, 8'd5, 1'b1, "R5 file full");

    // R7/R8 drain B, then reuse of its slot
    push_tgt(8'd2, 2'd1, 1'b1); fill_pulse(2'd1); wait_drain();
    push_mem(16'h0500, 2'd1); miss(16'h0500, 8'd5, 1'b0, "R8 freed entry reused");

    // R6 lowered limit
    cfg_limit = 3'd2;
    miss(16'h0600, 8'd7, 1'b1, "R6 limit below occupancy 4");
    push_tgt(8'd9, 2'd2, 1'b1); fill_pulse(2'd2); wait_drain();
    miss(16'h0600, 8'd7, 1'b1, "R6 occupancy 3");
    push_tgt(8'd10, 2'd3, 1'b1); fill_pulse(2'd3); wait_drain();
    miss(16'h0600, 8'd7, 1'b1, "R6 occupancy 2");
    push_tgt(8'd1, 2'd0, 1'b0); push_tgt(8'd3, 2'd0, 1'b1); fill_pulse(2'd0); wait_drain();
    push_mem(16'h0600, 2'd0); miss(16'h0600, 8'd7, 1'b0, "R6 alloc resumes");
    miss(16'h0800, 8'd11, 1'b1, "R6 limit reached again");

    // R8 stall hold, R9 no merge into draining entry
    cfg_limit = 3'd4;
    tgt_ready = 1'b0;
    push_tgt(8'd5, 2'd1, 1'b1); fill_pulse(2'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(tgt_valid == 1'b1,  "R8 stalled valid",  int'(tgt_valid), 1);
      check(tgt_data == 8'd5,   "R8 stalled data",   int'(tgt_data), 5);
      check(fill_ready == 1'b0, "R8 fill_ready low", int'(fill_ready), 0);
    end
    push_mem(16'h0500, 2'd2); miss(16'h0500, 8'd6, 1'b0, "R9 alloc not merge");
    tgt_ready = 1'b1;
    wait_drain();
    push_tgt(8'd6, 2'd2, 1'b1); fill_pulse(2'd2); wait_drain();

    // R10 and R5 with limit 1
    cfg_limit = 3'd1;
    @(negedge clk); #1;
    check(blocked == 1'b0, "R10 no request no block", int'(blocked), 0);
    miss(16'h0700, 8'd8, 1'b1, "R5 limit 1 reached");
    cfg_limit = 3'd4;
    push_mem(16'h0700, 2'd1); miss(16'h0700, 8'd8, 1'b0, "R2 lowest free after 0");
    push_tgt(8'd7, 2'd0, 1'b1); fill_pulse(2'd0); wait_drain();
    push_tgt(8'd8, 2'd1, 1'b1); fill_pulse(2'd1); wait_drain();

    repeat (2) @(negedge clk);
    check(exp_mem.size() == 0, "R2 all requests seen", exp_mem.size(), 0);
    check(exp_tgt.size() == 0, "R7 all targets seen",  exp_tgt.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule